// File: doc/BRIEF.md
# Infrared pulse-width decoder

This block turns the output of an infrared receiver into message words. The receiver pin is synchronised to the system clock and cleaned by a short glitch filter. The block then times each pulse and each space in units set by a programmable prescaler. A message starts with a leader symbol. Each later pulse/space pair is compared with a zero window set and a one window set, and the resulting bit is packed into a data word of up to 64 bits. The message closes once a space reaches the programmed free time.

When the message closes, the bit count is checked against a minimum and a maximum. A good message updates the data and count outputs and pulses `valid` for one cycle. Any malformed symbol or bad length pulses `error` for one cycle instead. Configuration selects the input polarity, the bit order and bit inversion. It also selects one of two code types: pulse-distance or pulse-length. The two other code-type values are reserved and always end in an error.

Top module: `ir_pwdec`

## Requirements
- R1: After reset, `valid` and `error` are 0, `data_out` is 0 and `bit_count` is 0.
- R2: Data bits are accepted only after a leader whose pulse and space both fall in the leader windows. A leader pulse outside its window raises `error` and produces no `valid`.
- R3: Time is measured in units of `prescale`+1 clocks. With `code_type`=1 (pulse-distance), each pulse/space pair is a bit: 0 when both widths lie in the zero windows, 1 when both lie in the one windows, and 0 when both windows match. The pulse before the free-time space is a stop marker and is not stored. A good message pulses `valid` for one cycle. `data_out` and `bit_count` change only on that cycle.
- R4: With `code_type`=0 (pulse-length), pairs are decoded as in R3. The pulse before the free-time space is a data bit, decided by the zero or one pulse window alone.
- R5: A message ends when a space reaches `free_time` units. It is valid only if `min_bits` <= bit count <= `max_bits`; otherwise `error` is pulsed. The count never exceeds the data width.
- R6: A data pair that matches neither the zero nor the one windows pulses `error` for one cycle and returns the block to idle. A following good message still decodes.
- R7: `active_high`=1 treats a high input as pulse; `active_high`=0 treats a low input as pulse.
- R8: `msb_first`=1 places the first received bit at position `bit_count`-1 and the last at bit 0. `msb_first`=0 places bit k of the message at position k.
- R9: `no_invert`=1 stores bits as received; `no_invert`=0 stores their complement.
- R10: Any window whose maximum is below its minimum matches only the minimum width.
- R11: While `enable` is 0 the decoder stays idle: no `valid`, no `error`, and `data_out` keeps its value.
- R12: With `code_type` 2 or 3, a matched leader raises `error` and no message becomes valid.
- R13: `valid` and `error` are never high together, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Raw receiver input |
| enable | input | 1 | Decoder enable |
| code_type | input | 2 | 0 pulse-length, 1 pulse-distance, 2/3 reserved |
| active_high | input | 1 | 1: high level is pulse |
| msb_first | input | 1 | 1: first bit is most significant |
| no_invert | input | 1 | 1: keep bits, 0: invert bits |
| prescale | input | PW | Clocks per time unit minus one |
| ldr_pulse_min | input | TW | Leader pulse minimum |
| ldr_pulse_max | input | TW | Leader pulse maximum |
| ldr_space_min | input | TW | Leader space minimum |
| ldr_space_max | input | TW | Leader space maximum |
| zero_pulse_min | input | TW | Zero pulse minimum |
| zero_pulse_max | input | TW | Zero pulse maximum |
| zero_space_min | input | TW | Zero space minimum |
| zero_space_max | input | TW | Zero space maximum |
| one_pulse_min | input | TW | One pulse minimum |
| one_pulse_max | input | TW | One pulse maximum |
| one_space_min | input | TW | One space minimum |
| one_space_max | input | TW | One space maximum |
| free_time | input | TW | Space length that ends a message |
| min_bits | input | CW | Minimum accepted bit count |
| max_bits | input | CW | Maximum accepted bit count |
| data_out | output | DATA_W | Last valid message word |
| bit_count | output | CW | Bit count of last valid message |
| valid | output | 1 | One-cycle good-message strobe |
| error | output | 1 | One-cycle error strobe |

## Verification
The length-window assertion assumes `min_bits` and `max_bits` hold steady across the cycle in which a message closes. The enable assertion assumes that a drop of `enable` is judged one clock later. The bench changes configuration only while the line is idle or while the decoder is disabled, and it waits for the synchroniser to settle before enabling again. Every symbol width it drives is a whole number of time units, placed clear of window edges except in the deliberate boundary and clamp cases.

// File: rtl/ir_pwdec_pkg.sv
package ir_pwdec_pkg;
   typedef enum logic [1:0] {
      CT_PLEN  = 2'd0,
      CT_PDIST = 2'd1,
      CT_BIPH  = 2'd2,
      CT_PPOS2 = 2'd3
   } code_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LPULSE,
      ST_LSPACE,
      ST_DPULSE,
      ST_DSPACE,
      ST_FINISH
   } state_t;

   localparam int NWIN   = 6;
   localparam int WIN_LP = 0;
   localparam int WIN_LS = 1;
   localparam int WIN_ZP = 2;
   localparam int WIN_ZS = 3;
   localparam int WIN_OP = 4;
   localparam int WIN_OS = 5;
endpackage

// File: rtl/ir_pwdec_front.sv
module ir_pwdec_front #(
   parameter int GLITCH_LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ir_in,
   input  logic active_high,
   output logic pulse_start,
   output logic pulse_end
);
   logic [1:0] sync;
   logic       raw;
   logic       clean;
   logic       pulse;
   logic       pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync <= '0;
      else        sync <= {sync[0], ir_in};
   end
   assign raw = sync[1];

   generate
      if (GLITCH_LEN > 0) begin : g_filt
         logic [GLITCH_LEN-1:0] hist;
         logic                  filt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist <= '0;
               filt <= 1'b0;
            end else begin
               hist <= (hist << 1) | GLITCH_LEN'(raw);
               if (raw && (&hist))        filt <= 1'b1;
               else if (!raw && !(|hist)) filt <= 1'b0;
            end
         end
         assign clean = filt;
      end else begin : g_nofilt
         assign clean = raw;
      end
   endgenerate

   assign pulse = (clean == active_high);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= pulse;
   end

   assign pulse_start = pulse & ~pulse_q;
   assign pulse_end   = ~pulse & pulse_q;
endmodule

// File: rtl/ir_pwdec_timer.sv
module ir_pwdec_timer #(
   parameter int TW = 16,
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [PW-1:0] prescale,
   output logic [TW-1:0] width
);
   localparam logic [TW-1:0] WMAX = '1;
   logic [PW-1:0] div;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div   <= '0;
         width <= '0;
      end else if (restart) begin
         if (prescale == '0) begin
            div   <= '0;
            width <= TW'(1);
         end else begin
            div   <= PW'(1);
            width <= '0;
         end
      end else if (div >= prescale) begin
         div <= '0;
         if (width != WMAX) width <= width + 1'b1;
      end else begin
         div <= div + 1'b1;
      end
   end
endmodule

// File: rtl/ir_pwdec_window.sv
module ir_pwdec_window #(
   parameter int TW = 16
) (
   input  logic [TW-1:0] val,
   input  logic [TW-1:0] lo,
   input  logic [TW-1:0] hi,
   output logic          hit
);
   logic [TW-1:0] hi_eff;
   assign hi_eff = (hi < lo) ? lo : hi;
   assign hit    = (val >= lo) && (val <= hi_eff);
endmodule

// File: rtl/ir_pwdec_pack.sv
module ir_pwdec_pack #(
   parameter int DATA_W = 64,
   parameter int CW     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              push,
   input  logic              bit_in,
   input  logic              msb_first,
   input  logic              no_invert,
   output logic [DATA_W-1:0] word,
   output logic [CW-1:0]     count,
   output logic              full
);
   logic b;
   assign b    = no_invert ? bit_in : ~bit_in;
   assign full = (count == CW'(DATA_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word  <= '0;
         count <= '0;
      end else if (clear) begin
         word  <= '0;
         count <= '0;
      end else if (push && !full) begin
         count <= count + 1'b1;
         if (msb_first) word <= {word[DATA_W-2:0], b};
         else           word <= word | (DATA_W'(b) << count);
      end
   end
endmodule

// File: rtl/ir_pwdec.sv
module ir_pwdec
   import ir_pwdec_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int TW         = 16,
   parameter int PW         = 8,
   parameter int GLITCH_LEN = 2,
   localparam int CW        = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ir_in,
   input  logic              enable,
   input  logic [1:0]        code_type,
   input  logic              active_high,
   input  logic              msb_first,
   input  logic              no_invert,
   input  logic [PW-1:0]     prescale,
   input  logic [TW-1:0]     ldr_pulse_min,
   input  logic [TW-1:0]     ldr_pulse_max,
   input  logic [TW-1:0]     ldr_space_min,
   input  logic [TW-1:0]     ldr_space_max,
   input  logic [TW-1:0]     zero_pulse_min,
   input  logic [TW-1:0]     zero_pulse_max,
   input  logic [TW-1:0]     zero_space_min,
   input  logic [TW-1:0]     zero_space_max,
   input  logic [TW-1:0]     one_pulse_min,
   input  logic [TW-1:0]     one_pulse_max,
   input  logic [TW-1:0]     one_space_min,
   input  logic [TW-1:0]     one_space_max,
   input  logic [TW-1:0]     free_time,
   input  logic [CW-1:0]     min_bits,
   input  logic [CW-1:0]     max_bits,
   output logic [DATA_W-1:0] data_out,
   output logic [CW-1:0]     bit_count,
   output logic              valid,
   output logic              error
);
   generate
      if (DATA_W < 2 || DATA_W > 64) begin : g_bad_dw
         $error("ir_pwdec: DATA_W must lie in 2..64");
      end
      if (TW < 4) begin : g_bad_tw
         $error("ir_pwdec: TW must be at least 4");
      end
      if (GLITCH_LEN < 0 || GLITCH_LEN > 8) begin : g_bad_gl
         $error("ir_pwdec: GLITCH_LEN must lie in 0..8");
      end
   endgenerate

   logic                    p_start, p_end;
   logic [TW-1:0]           width;
   logic [TW-1:0]           pw_q;
   logic [NWIN-1:0][TW-1:0] win_val, win_lo, win_hi;
   logic [NWIN-1:0]         hit;
   logic                    zero_hit, one_hit, ft_reached, ct_ok;
   state_t                  state, nxt;
   logic                    push, pbit, clr, fin_ok, abort;
   logic [DATA_W-1:0]       word;
   logic [CW-1:0]           count;
   logic                    full;

   ir_pwdec_front #(.GLITCH_LEN(GLITCH_LEN)) u_front (
      .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .active_high(active_high),
      .pulse_start(p_start), .pulse_end(p_end)
   );

   ir_pwdec_timer #(.TW(TW), .PW(PW)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(p_start | p_end),
      .prescale(prescale), .width(width)
   );

   always_comb begin
      win_val[WIN_LP] = width;  win_lo[WIN_LP] = ldr_pulse_min;  win_hi[WIN_LP] = ldr_pulse_max;
      win_val[WIN_LS] = width;  win_lo[WIN_LS] = ldr_space_min;  win_hi[WIN_LS] = ldr_space_max;
      win_val[WIN_ZP] = pw_q;   win_lo[WIN_ZP] = zero_pulse_min; win_hi[WIN_ZP] = zero_pulse_max;
      win_val[WIN_ZS] = width;  win_lo[WIN_ZS] = zero_space_min; win_hi[WIN_ZS] = zero_space_max;
      win_val[WIN_OP] = pw_q;   win_lo[WIN_OP] = one_pulse_min;  win_hi[WIN_OP] = one_pulse_max;
      win_val[WIN_OS] = width;  win_lo[WIN_OS] = one_space_min;  win_hi[WIN_OS] = one_space_max;
   end

   generate
      for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
         ir_pwdec_window #(.TW(TW)) u_win (
            .val(win_val[gi]), .lo(win_lo[gi]), .hi(win_hi[gi]), .hit(hit[gi])
         );
      end
   endgenerate

   assign zero_hit   = hit[WIN_ZP] & hit[WIN_ZS];
   assign one_hit    = hit[WIN_OP] & hit[WIN_OS];
   assign ft_reached = (width >= free_time);
   assign ct_ok      = (code_type == CT_PLEN) || (code_type == CT_PDIST);

   ir_pwdec_pack #(.DATA_W(DATA_W), .CW(CW)) u_pack (
      .clk(clk), .rst_n(rst_n), .clear(clr), .push(push), .bit_in(pbit),
      .msb_first(msb_first), .no_invert(no_invert),
      .word(word), .count(count), .full(full)
   );

   always_comb begin
      nxt    = state;
      push   = 1'b0;
      pbit   = 1'b0;
      clr    = 1'b0;
      fin_ok = 1'b0;
      abort  = 1'b0;
      case (state)
         ST_IDLE: if (p_start) nxt = ST_LPULSE;
         ST_LPULSE: begin
            if (p_end) begin
               if (hit[WIN_LP]) nxt = ST_LSPACE;
               else             abort = 1'b1;
            end
         end
         ST_LSPACE: begin
            if (p_start) begin
               if (!hit[WIN_LS] || !ct_ok) abort = 1'b1;
               else begin
                  clr = 1'b1;
                  nxt = ST_DPULSE;
               end
            end else if (ft_reached) begin
               abort = 1'b1;
            end
         end
         ST_DPULSE: if (p_end) nxt = ST_DSPACE;
         ST_DSPACE: begin
            if (p_start) begin
               if ((zero_hit || one_hit) && !full) begin
                  push = 1'b1;
                  pbit = !zero_hit;
                  nxt  = ST_DPULSE;
               end else begin
                  abort = 1'b1;
               end
            end else if (ft_reached) begin
               if (code_type == CT_PLEN) begin
                  if ((hit[WIN_ZP] || hit[WIN_OP]) && !full) begin
                     push = 1'b1;
                     pbit = !hit[WIN_ZP];
                     nxt  = ST_FINISH;
                  end else begin
                     abort = 1'b1;
                  end
               end else begin
                  nxt = ST_FINISH;
               end
            end
         end
         ST_FINISH: begin
            nxt = ST_IDLE;
            if (count >= min_bits && count <= max_bits) fin_ok = 1'b1;
            else                                        abort  = 1'b1;
         end
         default: nxt = ST_IDLE;
      endcase
      if (abort) nxt = ST_IDLE;
      if (!enable) begin
         nxt    = ST_IDLE;
         push   = 1'b0;
         clr    = 1'b0;
         fin_ok = 1'b0;
         abort  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pw_q      <= '0;
         data_out  <= '0;
         bit_count <= '0;
         valid     <= 1'b0;
         error     <= 1'b0;
      end else begin
         state <= nxt;
         valid <= fin_ok;
         error <= abort;
         if (p_end) pw_q <= width;
         if (fin_ok) begin
            data_out  <= word;
            bit_count <= count;
         end
      end
   end
endmodule

// File: rtl/ir_pwdec_checker.sv
module ir_pwdec_checker #(
   parameter int DATA_W = 64,
   parameter int CW     = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic [CW-1:0]     min_bits,
   input logic [CW-1:0]     max_bits,
   input logic [DATA_W-1:0] data_out,
   input logic [CW-1:0]     bit_count,
   input logic              valid,
   input logic              error
);
   assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid && error));

   assert_error_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> !error);

   assert_valid_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   assert_len_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (bit_count >= min_bits && bit_count <= max_bits));

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_count <= CW'(DATA_W));

   assert_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!valid && !error));

   assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> $stable(data_out));
endmodule

bind ir_pwdec ir_pwdec_checker #(.DATA_W(DATA_W), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .min_bits(min_bits),
   .max_bits(max_bits), .data_out(data_out), .bit_count(bit_count),
   .valid(valid), .error(error)
);

// File: tb/ir_pwdec_test.sv
`timescale 1ns/1ps
module ir_pwdec_test;
   localparam int DATA_W = 64;
   localparam int TW     = 16;
   localparam int PW     = 8;
   localparam int CW     = $clog2(DATA_W + 1);
   localparam int UNIT   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ir_in = 1'b0;
   logic enable = 1'b0;
   logic [1:0] code_type = 2'd1;
   logic active_high = 1'b1, msb_first = 1'b1, no_invert = 1'b1;
   logic [PW-1:0] prescale = PW'(UNIT - 1);
   logic [TW-1:0] lp_lo, lp_hi, ls_lo, ls_hi, zp_lo, zp_hi, zs_lo, zs_hi;
   logic [TW-1:0] op_lo, op_hi, os_lo, os_hi, ftime;
   logic [CW-1:0] min_bits, max_bits;
   logic [DATA_W-1:0] data_out;
   logic [CW-1:0] bit_count;
   logic valid, error;

   int n_chk = 0, n_fail = 0;
   int tot_valid = 0, tot_err = 0, tot_both = 0;
   logic [DATA_W-1:0] last_data = '0;
   logic [CW-1:0] last_cnt = '0;
   int base_v, base_e;

   always #2.5 clk = ~clk;

   ir_pwdec #(.DATA_W(DATA_W), .TW(TW), .PW(PW), .GLITCH_LEN(2)) uut (
      .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .enable(enable),
      .code_type(code_type), .active_high(active_high), .msb_first(msb_first),
      .no_invert(no_invert), .prescale(prescale),
      .ldr_pulse_min(lp_lo), .ldr_pulse_max(lp_hi),
      .ldr_space_min(ls_lo), .ldr_space_max(ls_hi),
      .zero_pulse_min(zp_lo), .zero_pulse_max(zp_hi),
      .zero_space_min(zs_lo), .zero_space_max(zs_hi),
      .one_pulse_min(op_lo), .one_pulse_max(op_hi),
      .one_space_min(os_lo), .one_space_max(os_hi),
      .free_time(ftime), .min_bits(min_bits), .max_bits(max_bits),
      .data_out(data_out), .bit_count(bit_count), .valid(valid), .error(error)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (valid) begin
            tot_valid = tot_valid + 1;
            last_data = data_out;
            last_cnt  = bit_count;
         end
         if (error) tot_err = tot_err + 1;
         if (valid && error) tot_both = tot_both + 1;
      end
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_word(input logic [63:0] pat, input int n,
                                            input logic msb, input logic keep);
      logic [63:0] w = '0;
      for (int i = 0; i < n; i++) begin
         logic b = keep ? pat[i] : ~pat[i];
         if (msb) w[n-1-i] = b;
         else     w[i]     = b;
      end
      return w;
   endfunction

   task automatic cfg_default();
      lp_lo = 14; lp_hi = 18; ls_lo = 6;  ls_hi = 10;
      zp_lo = 1;  zp_hi = 3;  zs_lo = 1;  zs_hi = 3;
      op_lo = 1;  op_hi = 3;  os_lo = 5;  os_hi = 7;
      ftime = 12; min_bits = 1; max_bits = CW'(DATA_W);
      code_type = 2'd1; msb_first = 1'b1; no_invert = 1'b1;
   endtask

   task automatic drive(input bit pls, input int units);
      ir_in = pls ? active_high : ~active_high;
      repeat (units * UNIT) @(negedge clk);
   endtask

   task automatic mark();
      @(negedge clk);
      base_v = tot_valid;
      base_e = tot_err;
   endtask

   task automatic send_pd(input logic [63:0] pat, input int n, input int ldr_p,
                          input int one_sp, input int bad_idx);
      mark();
      drive(1, ldr_p);
      drive(0, 8);
      for (int i = 0; i < n; i++) begin
         drive(1, 2);
         if (i == bad_idx) drive(0, 4);
         else              drive(0, pat[i] ? one_sp : 2);
      end
      drive(1, 2);
      drive(0, 20);
   endtask

   task automatic send_pl(input logic [63:0] pat, input int n);
      mark();
      drive(1, 16);
      drive(0, 8);
      for (int i = 0; i < n; i++) begin
         drive(1, pat[i] ? 4 : 2);
         if (i != n - 1) drive(0, 2);
      end
      drive(0, 20);
   endtask

   task automatic expect_good(input string tag, input logic [63:0] pat, input int n);
      check({tag, " valid count"}, 64'(tot_valid - base_v), 64'd1);
      check({tag, " error count"}, 64'(tot_err - base_e), 64'd0);
      check({tag, " data"}, last_data, exp_word(pat, n, msb_first, no_invert));
      check({tag, " bit_count"}, 64'(last_cnt), 64'(n));
   endtask

   task automatic expect_bad(input string tag);
      check({tag, " no valid"}, 64'(tot_valid - base_v), 64'd0);
      check({tag, " error seen"}, 64'((tot_err - base_e) > 0), 64'd1);
   endtask

   task automatic t_reset();
      check("R1 valid", 64'(valid), 64'd0);
      check("R1 error", 64'(error), 64'd0);
      check("R1 data_out", data_out, 64'd0);
      check("R1 bit_count", 64'(bit_count), 64'd0);
   endtask

   task automatic t_pd_basic();
      cfg_default();
      send_pd(64'hA5C3_0F96, 32, 16, 6, -1);
      expect_good("R3 pd 32 bits", 64'hA5C3_0F96, 32);
      send_pd(64'h0000_00FF_0000_0001, 48, 16, 6, -1);
      expect_good("R3 pd 48 bits", 64'h0000_00FF_0000_0001, 48);
   endtask

   task automatic t_order_invert();
      cfg_default();
      msb_first = 1'b0;
      send_pd(64'h0000_0000_00C3_5A17, 24, 16, 6, -1);
      expect_good("R8 lsb first", 64'h0000_0000_00C3_5A17, 24);
      msb_first = 1'b1;
      no_invert = 1'b0;
      send_pd(64'h0000_0000_0000_9D2C, 16, 16, 6, -1);
      expect_good("R9 inverted", 64'h0000_0000_0000_9D2C, 16);
      no_invert = 1'b1;
   endtask

   task automatic t_plen();
      cfg_default();
      code_type = 2'd0; msb_first = 1'b0;
      zp_lo = 1; zp_hi = 3; zs_lo = 1; zs_hi = 3;
      op_lo = 4; op_hi = 5; os_lo = 1; os_hi = 3;
      send_pl(64'h0000_0000_0000_0A95, 12);
      expect_good("R4 pulse-length last bit one", 64'h0000_0000_0000_0A95, 12);
      send_pl(64'h0000_0000_0000_0455, 12);
      expect_good("R4 pulse-length last bit zero", 64'h0000_0000_0000_0455, 12);
      cfg_default();
   endtask

   task automatic t_length();
      cfg_default();
      min_bits = 8; max_bits = 16;
      send_pd(64'h0000_0000_0000_00B1, 8, 16, 6, -1);
      expect_good("R5 min length", 64'h0000_0000_0000_00B1, 8);
      send_pd(64'h0000_0000_0000_E74B, 16, 16, 6, -1);
      expect_good("R5 max length", 64'h0000_0000_0000_E74B, 16);
      send_pd(64'h0000_0000_0000_0005, 4, 16, 6, -1);
      expect_bad("R5 too short");
      send_pd(64'h0000_0000_000F_0F0F, 20, 16, 6, -1);
      expect_bad("R5 too long");
      cfg_default();
   endtask

   task automatic t_leader_mismatch();
      cfg_default();
      send_pd(64'h0000_0000_0000_3C3C, 16, 10, 6, -1);
      expect_bad("R2 short leader");
      send_pd(64'h0000_0000_0000_3C3C, 16, 16, 6, 5);
      expect_bad("R6 bad symbol");
      send_pd(64'h0000_0000_0000_3C3C, 16, 16, 6, -1);
      expect_good("R6 recovery", 64'h0000_0000_0000_3C3C, 16);
   endtask

   task automatic t_polarity();
      cfg_default();
      enable = 1'b0; active_high = 1'b0; ir_in = 1'b1;
      repeat (20) @(negedge clk);
      enable = 1'b1;
      send_pd(64'h0000_0000_0000_6B, 8, 16, 6, -1);
      expect_good("R7 active low", 64'h0000_0000_0000_6B, 8);
      enable = 1'b0; active_high = 1'b1; ir_in = 1'b0;
      repeat (20) @(negedge clk);
      enable = 1'b1;
      send_pd(64'h0000_0000_0000_94, 8, 16, 6, -1);
      expect_good("R7 active high", 64'h0000_0000_0000_94, 8);
   endtask

   task automatic t_clamp();
      cfg_default();
      os_lo = 5; os_hi = 0;
      send_pd(64'h0000_0000_0000_00F1, 8, 16, 6, -1);
      expect_bad("R10 clamped max rejects 6");
      send_pd(64'h0000_0000_0000_00F1, 8, 16, 5, -1);
      expect_good("R10 clamped max accepts min", 64'h0000_0000_0000_00F1, 8);
      cfg_default();
   endtask

   task automatic t_enable();
      logic [DATA_W-1:0] held;
      cfg_default();
      held = data_out;
      enable = 1'b0;
      send_pd(64'h0000_0000_1234_5678, 32, 16, 6, -1);
      check("R11 no valid while disabled", 64'(tot_valid - base_v), 64'd0);
      check("R11 no error while disabled", 64'(tot_err - base_e), 64'd0);
      check("R11 data_out held", data_out, held);
      enable = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   task automatic t_ctype();
      cfg_default();
      code_type = 2'd2;
      send_pd(64'h0000_0000_0000_5555, 16, 16, 6, -1);
      expect_bad("R12 code type 2");
      code_type = 2'd3;
      send_pd(64'h0000_0000_0000_5555, 16, 16, 6, -1);
      expect_bad("R12 code type 3");
      cfg_default();
   endtask

   task automatic finish_run();
      check("R13 valid and error together", 64'(tot_both), 64'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      cfg_default();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      enable = 1'b1;
      repeat (10) @(negedge clk);
      t_pd_basic();
      t_order_invert();
      t_plen();
      t_length();
      t_leader_mismatch();
      t_polarity();
      t_clamp();
      t_enable();
      t_ctype();
      finish_run();
   end
endmodule